// File: doc/BRIEF.md
# I2C Slave Command Front End

This block is the message layer of an I2C-to-SPI bridge. A bit-level I2C engine hands it START and STOP events and received bytes. The block answers each byte with ACK or NACK and supplies read data. Write messages are collected in a 200-byte buffer. The first byte after the address selects an operation. That operation is launched only when the STOP arrives, through one-cycle strobes to an SPI engine, a configuration register and a GPIO controller. The block also drives an idle flag and an active-low interrupt.

While an SPI transfer or a GPIO sample is running, the block is busy and refuses its own address. The SPI engine and the GPIO controller reach the buffer through a side port and report completion with `op_done`. A read message needs no command byte. It streams the buffer from index 0 and leaves the contents unchanged.

Received bytes arrive on a valid/ready channel. A byte is accepted when `rx_valid` and `rx_ready` are both high. `rx_ready` drops for the cycle after each accepted byte, while that byte's answer is presented on `ack_valid`/`ack`. `rx_ready` is also low in any cycle carrying a START or STOP event. Read data uses a valid/ready channel in the other direction: `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low, and a byte is consumed only when both are high.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: The first byte after START is an address byte. Bits [7:1] are compared with the 7-bit value {0101, strap}, and bit 0 selects write (0) or read (1). The block answers on `ack_valid`/`ack` in the cycle after acceptance: ACK on a match, NACK otherwise. After a NACK it ignores the bus until the next START.
- R2: The strap value is sampled once, on the first clock edge after reset is released. Later changes on `strap_addr` do not change the address.
- R3: In a write message, the byte after the address is the command and is always ACKed. The following data bytes are ACKed and stored at buffer indices 0, 1, 2 and so on.
- R4: Data bytes beyond 200 are NACKed and not stored. The stored count stays at 200.
- R5: From the STOP that launches an SPI transfer or a GPIO sample until `op_done`, the block NACKs its own address.
- R6: A command in 01h..0Fh, closed by STOP, pulses `spi_go` for one cycle. The pulse comes in the cycle after the STOP event is sampled, with `spi_ss` equal to the command's low nibble and `spi_len` equal to the number of stored data bytes. It also sets busy.
- R7: Commands F0h, F4h, F6h and F7h pulse `cfg_we`, `gpio_out_we`, `gpio_en_we` and `gpio_mode_we` respectively, with `cmd_arg` equal to the first data byte. They do not set busy. Without a data byte the command does nothing. At most one strobe is high in any cycle.
- R8: Command F5h pulses `gpio_rd_go` and sets busy. A following read returns buffer index 0, as written through the side port, then FFh.
- R9: `int_n` is high after reset. It goes low on the `op_done` that ends an SPI transfer, and returns high on command F1h.
- R10: Command F2h sets `idle`. `idle` clears when the block's own address is matched.
- R11: A read message returns buffer bytes from index 0. Beyond the valid length it returns FFh. The valid length is the data count of the last write message, or 1 after F5h. Reads leave the buffer unchanged.
- R12: A command outside the listed set produces no strobe and does not set busy.
- R13: `rx_ready` is low in the cycle after an accepted byte. `tx_data` is held while `tx_valid` is high and `tx_ready` is low.
- R14: While busy, writes on the side port (`eng_we`, `eng_addr`, `eng_wdata`) update the buffer, and `eng_rdata` shows the byte at `eng_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Low address bits, sampled once after reset |
| ev_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| ev_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | Received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| ack_valid | output | 1 | Answer for the last accepted byte is present |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Read byte is present |
| tx_data | output | 8 | Read byte |
| tx_ready | input | 1 | Bit engine takes the read byte |
| spi_go | output | 1 | Start SPI transfer (one-cycle pulse) |
| spi_ss | output | 4 | Slave-select mask for the transfer |
| spi_len | output | 8 | Byte count for the transfer |
| eng_addr | input | 8 | Side-port buffer index |
| eng_we | input | 1 | Side-port write enable (effective while busy) |
| eng_wdata | input | 8 | Side-port write byte |
| eng_rdata | output | 8 | Side-port read byte |
| op_done | input | 1 | Running operation finished (one-cycle pulse) |
| cfg_we | output | 1 | Load SPI configuration from cmd_arg |
| gpio_out_we | output | 1 | Load GPIO output levels from cmd_arg |
| gpio_en_we | output | 1 | Load GPIO enable mask from cmd_arg |
| gpio_mode_we | output | 1 | Load GPIO pin modes from cmd_arg |
| gpio_rd_go | output | 1 | Sample GPIO pins into buffer index 0 |
| cmd_arg | output | 8 | Argument for the strobes above |
| idle | output | 1 | Low-power request |
| int_n | output | 1 | Interrupt, active low |

## Verification
The address path is swept over all 128 addresses with both R/W values. This separates a correct match on the strap value captured at reset from a match on the changed strap pins or on a neighbouring address. The dispatcher is swept over all 256 command codes with a one-byte argument. This shows that exactly the listed codes produce their own strobe, that the SPI range decodes its mask and length, and that every other code leaves the block free for the next address.

Directed messages cover several further cases: a 202-byte write that crosses the capacity limit, an SPI transfer whose results are written back and read twice past their end, a GPIO sample, argument-less commands, the interrupt and idle transitions, and the NACK during busy.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  typedef enum logic [2:0] {L_IDLE, L_ADDR, L_CMD, L_DATA, L_READ} link_st_t;
  typedef enum logic [1:0] {K_NONE, K_SPI, K_GPRD} op_kind_t;

  localparam logic [3:0] ADDR_HI   = 4'b0101;
  localparam logic [7:0] OP_CFG    = 8'hF0;
  localparam logic [7:0] OP_INTCLR = 8'hF1;
  localparam logic [7:0] OP_IDLE   = 8'hF2;
  localparam logic [7:0] OP_GPWR   = 8'hF4;
  localparam logic [7:0] OP_GPRD   = 8'hF5;
  localparam logic [7:0] OP_GPEN   = 8'hF6;
  localparam logic [7:0] OP_GPMODE = 8'hF7;
endpackage

// File: rtl/i2cfe_buffer.sv
module i2cfe_buffer #(
  parameter int DEPTH = 200,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b,
  output logic [7:0]    rdata_0
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  // Indices past the storage read as all ones.
  assign rdata_a = (int'(raddr_a) < DEPTH) ? mem[raddr_a] : 8'hFF;
  assign rdata_b = (int'(raddr_b) < DEPTH) ? mem[raddr_b] : 8'hFF;
  assign rdata_0 = mem[0];
endmodule

// File: rtl/i2cfe_link.sv
module i2cfe_link import i2cfe_pkg::*; #(
  parameter int DEPTH = 200,
  parameter int AW    = 8,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap_addr,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          ack_valid,
  output logic          ack,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          busy,
  input  logic [CW-1:0] valid_len,
  input  logic [7:0]    buf_rdata,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [CW-1:0] wcount,
  output logic [7:0]    cmd_q,
  output logic          msg_end,
  output logic          wake
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  link_st_t      st;
  logic          armed;
  logic [2:0]    strap_q;
  logic [CW-1:0] rptr;
  logic          accept, match, ack_now;

  // One-time capture of the strap pins on the first edge out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      strap_q <= '0;
    end else if (!armed) begin
      armed   <= 1'b1;
      strap_q <= strap_addr;
    end
  end

  assign rx_ready = !ack_valid && !ev_start && !ev_stop;
  assign accept   = rx_valid && rx_ready;
  assign match    = (rx_data[7:1] == {ADDR_HI, strap_q});

  always_comb begin
    case (st)
      L_ADDR:  ack_now = match && !busy;
      L_CMD:   ack_now = 1'b1;
      L_DATA:  ack_now = (wcount < FULL);
      default: ack_now = 1'b0;
    endcase
  end

  assign wr_en    = accept && (st == L_DATA) && (wcount < FULL);
  assign wr_addr  = AW'(wcount);
  assign wr_data  = rx_data;
  assign wake     = accept && (st == L_ADDR) && match && !busy;
  assign msg_end  = ev_stop && (st == L_DATA);
  assign tx_valid = (st == L_READ);
  assign rd_addr  = AW'(rptr);
  assign tx_data  = (rptr < valid_len) ? buf_rdata : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= L_IDLE;
      wcount    <= '0;
      rptr      <= '0;
      cmd_q     <= '0;
      ack_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_valid <= accept;
      ack       <= accept && ack_now;
      if (tx_valid && tx_ready && (rptr != FULL)) rptr <= rptr + 1'b1;
      if (ev_start) begin
        st <= L_ADDR;
      end else if (ev_stop) begin
        st <= L_IDLE;
      end else if (accept) begin
        case (st)
          L_ADDR: begin
            if (ack_now) begin
              st     <= rx_data[0] ? L_READ : L_CMD;
              wcount <= '0;
              rptr   <= '0;
            end else begin
              st <= L_IDLE;
            end
          end
          L_CMD: begin
            cmd_q <= rx_data;
            st    <= L_DATA;
          end
          L_DATA: if (wr_en) wcount <= wcount + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R5: own address refused while an operation runs
  assert_nack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st == L_ADDR && busy) |=> (ack_valid && !ack));

  // R4: a full buffer refuses the byte and keeps its count
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && st == L_DATA && wcount == FULL) |=> (ack_valid && !ack && wcount == FULL));

  // R13: read byte held under back-pressure
  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ev_start && !ev_stop) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/i2cfe_dispatch.sv
module i2cfe_dispatch import i2cfe_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msg_end,
  input  logic [7:0]    cmd_q,
  input  logic [CW-1:0] wcount,
  input  logic [7:0]    arg0,
  input  logic          wake,
  input  logic          op_done,
  output logic          spi_go,
  output logic [3:0]    spi_ss,
  output logic [CW-1:0] spi_len,
  output logic          cfg_we,
  output logic          gpio_out_we,
  output logic          gpio_en_we,
  output logic          gpio_mode_we,
  output logic          gpio_rd_go,
  output logic [7:0]    cmd_arg,
  output logic          idle,
  output logic          int_n,
  output logic          busy,
  output logic [CW-1:0] valid_len
);
  op_kind_t kind;
  logic     is_spi, has_arg, is_known;

  assign is_spi   = (cmd_q[7:4] == 4'h0) && (cmd_q[3:0] != 4'h0);
  assign has_arg  = (wcount != '0);
  assign is_known = is_spi || (cmd_q inside {OP_CFG, OP_INTCLR, OP_IDLE, OP_GPWR,
                                             OP_GPRD, OP_GPEN, OP_GPMODE});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_go <= 1'b0; spi_ss <= '0; spi_len <= '0;
      cfg_we <= 1'b0; gpio_out_we <= 1'b0; gpio_en_we <= 1'b0;
      gpio_mode_we <= 1'b0; gpio_rd_go <= 1'b0; cmd_arg <= '0;
      idle <= 1'b0; int_n <= 1'b1; busy <= 1'b0; kind <= K_NONE;
      valid_len <= '0;
    end else begin
      spi_go <= 1'b0; cfg_we <= 1'b0; gpio_out_we <= 1'b0;
      gpio_en_we <= 1'b0; gpio_mode_we <= 1'b0; gpio_rd_go <= 1'b0;
      if (op_done && busy) begin
        busy <= 1'b0;
        kind <= K_NONE;
        if (kind == K_SPI) int_n <= 1'b0;
      end
      if (wake) idle <= 1'b0;
      if (msg_end) begin
        valid_len <= wcount;
        if (is_spi) begin
          spi_go  <= 1'b1;
          spi_ss  <= cmd_q[3:0];
          spi_len <= wcount;
          busy    <= 1'b1;
          kind    <= K_SPI;
        end else begin
          case (cmd_q)
            OP_CFG:    if (has_arg) begin cfg_we <= 1'b1;       cmd_arg <= arg0; end
            OP_GPWR:   if (has_arg) begin gpio_out_we <= 1'b1;  cmd_arg <= arg0; end
            OP_GPEN:   if (has_arg) begin gpio_en_we <= 1'b1;   cmd_arg <= arg0; end
            OP_GPMODE: if (has_arg) begin gpio_mode_we <= 1'b1; cmd_arg <= arg0; end
            OP_INTCLR: int_n <= 1'b1;
            OP_IDLE:   idle <= 1'b1;
            OP_GPRD: begin
              gpio_rd_go <= 1'b1;
              busy       <= 1'b1;
              kind       <= K_GPRD;
              valid_len  <= CW'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R7: strobes never overlap
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spi_go, cfg_we, gpio_out_we, gpio_en_we, gpio_mode_we, gpio_rd_go}));

  // R9: the interrupt only falls on completion of a running operation
  assert_int_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(op_done && busy));

  // R6 / R8: busy only rises together with a launching strobe
  assert_busy_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (spi_go || gpio_rd_go));

  // R12: unlisted codes launch nothing
  assert_unknown_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && !is_known) |=> !(spi_go || cfg_we || gpio_out_we || gpio_en_we ||
                                 gpio_mode_we || gpio_rd_go));
endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend #(
  parameter  int DEPTH = 200,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap_addr,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          ack_valid,
  output logic          ack,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          spi_go,
  output logic [3:0]    spi_ss,
  output logic [CW-1:0] spi_len,
  input  logic [AW-1:0] eng_addr,
  input  logic          eng_we,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata,
  input  logic          op_done,
  output logic          cfg_we,
  output logic          gpio_out_we,
  output logic          gpio_en_we,
  output logic          gpio_mode_we,
  output logic          gpio_rd_go,
  output logic [7:0]    cmd_arg,
  output logic          idle,
  output logic          int_n
);
  logic          busy, lk_we, msg_end, wake, mem_we;
  logic [AW-1:0] lk_waddr, rd_addr, mem_waddr;
  logic [7:0]    lk_wdata, mem_wdata, rd_data, arg0, cmd_q;
  logic [CW-1:0] wcount, valid_len;

  // Bus writes own the port; the side port writes only while an operation runs.
  assign mem_we    = lk_we || (eng_we && busy);
  assign mem_waddr = lk_we ? lk_waddr : eng_addr;
  assign mem_wdata = lk_we ? lk_wdata : eng_wdata;

  i2cfe_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(rd_addr), .rdata_a(rd_data),
    .raddr_b(eng_addr), .rdata_b(eng_rdata),
    .rdata_0(arg0)
  );

  i2cfe_link #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_link (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ack_valid(ack_valid), .ack(ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .busy(busy), .valid_len(valid_len), .buf_rdata(rd_data), .rd_addr(rd_addr),
    .wr_en(lk_we), .wr_addr(lk_waddr), .wr_data(lk_wdata),
    .wcount(wcount), .cmd_q(cmd_q), .msg_end(msg_end), .wake(wake)
  );

  i2cfe_dispatch #(.CW(CW)) u_disp (
    .clk(clk), .rst_n(rst_n), .msg_end(msg_end), .cmd_q(cmd_q),
    .wcount(wcount), .arg0(arg0), .wake(wake), .op_done(op_done),
    .spi_go(spi_go), .spi_ss(spi_ss), .spi_len(spi_len),
    .cfg_we(cfg_we), .gpio_out_we(gpio_out_we), .gpio_en_we(gpio_en_we),
    .gpio_mode_we(gpio_mode_we), .gpio_rd_go(gpio_rd_go), .cmd_arg(cmd_arg),
    .idle(idle), .int_n(int_n), .busy(busy), .valid_len(valid_len)
  );
endmodule

// File: tb/sim_i2c_cmd_frontend.sv
module sim_i2c_cmd_frontend;
  localparam int DEPTH = 200;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam logic [6:0] MY = 7'h2D;   // {0101, strap 101}

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap_addr = 3'b101;
  logic ev_start = 0, ev_stop = 0, rx_valid = 0, tx_ready = 0, eng_we = 0, op_done = 0;
  logic [7:0] rx_data = 0, eng_wdata = 0;
  logic [AW-1:0] eng_addr = 0;
  logic rx_ready, ack_valid, ack, tx_valid, spi_go, cfg_we, gpio_out_we, gpio_en_we;
  logic gpio_mode_we, gpio_rd_go, idle, int_n;
  logic [7:0] tx_data, eng_rdata, cmd_arg;
  logic [3:0] spi_ss;
  logic [CW-1:0] spi_len;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_mem [256];
  logic exp_int = 1'b1;

  i2c_cmd_frontend #(.DEPTH(DEPTH)) u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    ev_start = 1; @(negedge clk); ev_start = 0;
  endtask

  task automatic bus_stop();
    ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask

  task automatic put_byte(input logic [7:0] d, output logic a);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    a = ack_valid && ack;
  endtask

  task automatic get_byte(output logic [7:0] d);
    d = tx_valid ? tx_data : 8'hXX;
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic finish_op();
    op_done = 1; @(negedge clk); op_done = 0;
  endtask

  task automatic eng_write(input int idx, input logic [7:0] d);
    eng_addr = AW'(idx); eng_wdata = d; eng_we = 1;
    @(negedge clk); eng_we = 0;
  endtask

  initial begin
    logic a;
    logic [7:0] d, t0;
    int exp_vec;
    repeat (3) @(negedge clk);
    chk("R9 reset int_n", int_n, 1);
    chk("R10 reset idle", idle, 0);
    chk("R11 reset tx_valid", tx_valid, 0);
    chk("R6 reset spi_go", spi_go, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    strap_addr = 3'b010;   // R2: must not move the address

    // R1 / R2: full address sweep
    for (int ad = 0; ad < 128; ad++) begin
      for (int rw = 0; rw < 2; rw++) begin
        bus_start();
        put_byte({ad[6:0], rw[0]}, a);
        if (ad == 0 && rw == 0) chk("R13 rx_ready gap", rx_ready, 0);
        chk($sformatf("R1 R2 addr %0h rw %0d", ad, rw), a, (ad == MY));
        if (ad == MY && rw == 1) chk("R1 read path", tx_valid, 1);
        bus_stop();
      end
    end

    // R3 / R6: SPI transfer with six data bytes on mask 5
    bus_start();
    put_byte({MY, 1'b0}, a); chk("R3 addr", a, 1);
    put_byte(8'h05, a);      chk("R3 cmd ack", a, 1);
    for (int i = 0; i < 6; i++) begin
      exp_mem[i] = 8'(16 + i * 9);
      put_byte(exp_mem[i], a); chk("R3 data ack", a, 1);
    end
    bus_stop();
    chk("R6 spi_go", spi_go, 1);
    chk("R6 spi_ss", spi_ss, 5);
    chk("R6 spi_len", spi_len, 6);
    @(negedge clk);
    chk("R6 spi_go pulse", spi_go, 0);

    // R5: busy refuses address
    bus_start(); put_byte({MY, 1'b1}, a); chk("R5 nack busy", a, 0); bus_stop();

    // R14 / R3: side port sees stored data, then writes results
    for (int i = 0; i < 6; i++) begin
      eng_addr = AW'(i); #1;
      chk("R3 R14 stored byte", eng_rdata, exp_mem[i]);
      exp_mem[i] = 8'(8'hA0 ^ (i * 3));
      eng_write(i, exp_mem[i]);
    end
    finish_op();
    chk("R9 int after spi", int_n, 0);

    // R11 / R13: read back twice, past the end
    bus_start(); put_byte({MY, 1'b1}, a); chk("R11 addr", a, 1);
    t0 = tx_data; @(negedge clk);
    chk("R13 tx hold valid", tx_valid, 1);
    chk("R13 tx hold data", tx_data, t0);
    for (int i = 0; i < 8; i++) begin
      get_byte(d);
      chk($sformatf("R11 R14 read %0d", i), d, (i < 6) ? exp_mem[i] : 8'hFF);
    end
    bus_stop();
    bus_start(); put_byte({MY, 1'b1}, a);
    for (int i = 0; i < 3; i++) begin
      get_byte(d); chk("R11 reread unchanged", d, exp_mem[i]);
    end
    bus_stop();

    // R9: clear interrupt
    bus_start(); put_byte({MY, 1'b0}, a); put_byte(8'hF1, a); bus_stop();
    exp_int = 1'b1;
    chk("R9 int cleared", int_n, 1);

    // R6 R7 R8 R10 R12: every command code with one argument
    for (int c = 0; c < 256; c++) begin
      logic [7:0] arg;
      arg = 8'(c) ^ 8'h3C;
      bus_start();
      put_byte({MY, 1'b0}, a);
      chk($sformatf("R12 addr free before %0h", c), a, 1);
      chk("R10 idle cleared by address", idle, 0);
      put_byte(8'(c), a);
      put_byte(arg, a);
      bus_stop();
      exp_vec = 0;
      if (c >= 1 && c <= 15) exp_vec = 32;
      if (c == 8'hF0) exp_vec = 16;
      if (c == 8'hF4) exp_vec = 8;
      if (c == 8'hF6) exp_vec = 4;
      if (c == 8'hF7) exp_vec = 2;
      if (c == 8'hF5) exp_vec = 1;
      chk($sformatf("R6 R7 R12 strobes cmd %0h", c),
          {spi_go, cfg_we, gpio_out_we, gpio_en_we, gpio_mode_we, gpio_rd_go}, exp_vec);
      if (exp_vec inside {16, 8, 4, 2}) chk("R7 cmd_arg", cmd_arg, arg);
      if (exp_vec == 32) begin
        chk("R6 mask", spi_ss, c & 15);
        chk("R6 length one", spi_len, 1);
      end
      if (c == 8'hF1) exp_int = 1'b1;
      chk("R10 idle set", idle, (c == 8'hF2));
      if (exp_vec == 32 || exp_vec == 1) begin
        finish_op();
        if (exp_vec == 32) exp_int = 1'b0;
      end
      chk($sformatf("R9 int after %0h", c), int_n, exp_int);
    end

    // R8: GPIO sample lands in index 0
    bus_start(); put_byte({MY, 1'b0}, a); put_byte(8'hF5, a); bus_stop();
    chk("R8 gpio_rd_go", gpio_rd_go, 1);
    bus_start(); put_byte({MY, 1'b0}, a); chk("R8 R5 busy nack", a, 0); bus_stop();
    eng_write(0, 8'h77);
    finish_op();
    bus_start(); put_byte({MY, 1'b1}, a); chk("R8 addr after done", a, 1);
    get_byte(d); chk("R8 sample byte", d, 8'h77);
    get_byte(d); chk("R8 R11 past length", d, 8'hFF);
    bus_stop();

    // R7: argument-less commands do nothing
    bus_start(); put_byte({MY, 1'b0}, a); put_byte(8'hF0, a); bus_stop();
    chk("R7 no arg cfg", cfg_we, 0);
    bus_start(); put_byte({MY, 1'b0}, a); put_byte(8'hF4, a); bus_stop();
    chk("R7 no arg gpio", gpio_out_we, 0);

    // R4: capacity limit
    bus_start(); put_byte({MY, 1'b0}, a); put_byte(8'h01, a);
    for (int i = 0; i < 202; i++) begin
      put_byte(8'(i * 13 + 7), a);
      if (i < DEPTH) exp_mem[i] = 8'(i * 13 + 7);
      if (i >= DEPTH - 1) chk($sformatf("R4 ack byte %0d", i), a, (i < DEPTH));
    end
    bus_stop();
    chk("R4 length capped", spi_len, DEPTH);
    finish_op();
    bus_start(); put_byte({MY, 1'b1}, a);
    for (int i = 0; i < 201; i++) begin
      get_byte(d);
      if (i == 0 || i >= 198) chk($sformatf("R4 R11 read %0d", i), d, (i < DEPTH) ? exp_mem[i] : 8'hFF);
      else if (d !== exp_mem[i]) chk("R4 stored byte", d, exp_mem[i]);
    end
    bus_stop();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule